// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block holds the replacement state of a set-associative cache that uses a not-recently-used policy, and picks the way to evict. Every way of every set has one flag. A flag reads one while its way is an eviction candidate. It reads zero once the way has been used.

The cache controller reports each hit or fill as a touch event, which gives a set index and a way number. The block clears that way's flag. If that clear would leave every flag of the set at zero, the whole set is re-armed to all ones in the same update.

Independently of touches, the controller presents a set index on the query port. It reads back the victim way combinationally: this is the lowest-numbered way whose flag is one. Tags, data and miss handling stay in the controller.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset is asserted (rst_n low, asynchronous), every flag of every set is one, so the victim of every set is way 0.
- R2: A touch (touch_en high at a rising clock edge) clears the flag of way touch_way in set touch_set, unless R4 applies.
- R3: victim_way is the lowest-numbered way whose flag is one in set query_set.
- R4: When a touch would leave every flag of its set at zero, all flags of that set become one instead, in the same clock edge. A set's flags are therefore never all zero.
- R5: A touch changes no flag of any set other than touch_set.
- R6: victim_way depends only on the stored flags. A touch and a query to the same set in the same cycle return the victim from before the touch, and the new victim appears after the clock edge.
- R7: Touching a way whose flag is already zero changes nothing, unless R4 applies.
- R8: While touch_en is low, no flag changes, whatever touch_set and touch_way carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_en | input | 1 | Touch event valid |
| touch_set | input | SET_W | Set index of the touch |
| touch_way | input | WAY_W | Way number of the touch |
| query_set | input | SET_W | Set index to query |
| victim_way | output | WAY_W | Way to evict in query_set |

## Verification
A wrong flag shows up on victim_way only when it is the lowest set flag of the queried set. A flag above that one stays hidden until lower ways are touched. The bench therefore compares against its model on every cycle with a random query set. It also sweeps all sets after each directed scenario, so that a stray write to a neighbouring set or a missed re-arm shows up within one sweep. Long random runs drive each set through many re-arm rounds, which exposes any flag that was corrupted and stayed hidden.

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);

  logic [SETS-1:0][WAYS-1:0] flags_q;
  logic [WAYS-1:0] hit_vec, cleared_vec, next_vec, query_vec;

  assign hit_vec     = flags_q[touch_set];
  assign cleared_vec = hit_vec & ~(WAYS'(1) << touch_way);
  assign next_vec    = (cleared_vec == '0) ? '1 : cleared_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '1;
    else if (touch_en) flags_q[touch_set] <= next_vec;
  end

  assign query_vec = flags_q[query_set];

  always_comb begin
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (query_vec[w]) victim_way = WAY_W'(w);
  end

endmodule

// File: rtl/nru_victim_chk.sv
module nru_victim_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      touch_en,
  input logic [SET_W-1:0]          touch_set,
  input logic [WAY_W-1:0]          touch_way,
  input logic [SET_W-1:0]          query_set,
  input logic [WAY_W-1:0]          victim_way,
  input logic [SETS-1:0][WAYS-1:0] flags_q
);

  logic [WAYS-1:0] qv;
  assign qv = flags_q[query_set];

  a_r3_victim_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    qv[victim_way] == 1'b1);

  a_r3_lower_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (qv & ((WAYS'(1) << victim_way) - WAYS'(1))) == '0);

  a_r2_touched_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (flags_q[$past(touch_set)][$past(touch_way)] == 1'b0)
                 || (flags_q[$past(touch_set)] == '1));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(flags_q));

  for (genvar s = 0; s < SETS; s++) begin : g_set
    a_r4_never_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[s] != '0);
    a_r5_other_sets_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(touch_en && touch_set == SET_W'(s)) |=> $stable(flags_q[s]));
  end

endmodule

bind nru_victim_sel nru_victim_chk #(.WAYS(WAYS), .SETS(SETS)) chk_i (
  .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
  .touch_way(touch_way), .query_set(query_set), .victim_way(victim_way),
  .flags_q(flags_q)
);

// File: tb/nru_victim_sel_tb.sv
`timescale 1ns/100ps
module nru_victim_sel_tb_top;
  localparam int WAYS = 4;
  localparam int SETS = 16;

  logic clk = 0, rst_n = 0, touch_en = 0;
  logic [3:0] touch_set = 0, query_set = 0;
  logic [1:0] touch_way = 0, victim_way;
  int checks = 0, errors = 0;
  bit done = 0;
  bit mdl [SETS][WAYS];

  always #2.5 clk = ~clk;

  nru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
    .touch_way(touch_way), .query_set(query_set), .victim_way(victim_way));

  function automatic int mdl_victim(int s);
    for (int w = 0; w < WAYS; w++) if (mdl[s][w]) return w;
    return -1;
  endfunction

  function automatic void mdl_touch(int s, int w);
    int ones = 0;
    mdl[s][w] = 0;
    for (int k = 0; k < WAYS; k++) ones += mdl[s][k];
    if (ones == 0) for (int k = 0; k < WAYS; k++) mdl[s][k] = 1;
  endfunction

  task automatic check(string req, int exp);
    checks++;
    if (int'(victim_way) != exp) begin
      errors++;
      $display("FAIL %s set %0d: victim %0d expected %0d", req, query_set, victim_way, exp);
    end
  endtask

  task automatic step(bit en, int s, int w, int q, string req);
    @(negedge clk);
    touch_en = en; touch_set = 4'(s); touch_way = 2'(w); query_set = 4'(q);
    #1 check(req, mdl_victim(q));
    @(posedge clk);
    if (en) mdl_touch(s, w);
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < SETS; s++) step(1'b0, (s * 7) % SETS, s % WAYS, s, req);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mdl[s][w] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    sweep("R1");
    step(1, 3, 0, 3, "R2");
    step(0, 0, 0, 3, "R2");
    sweep("R5");
    step(1, 5, 2, 5, "R3");
    step(1, 5, 0, 5, "R3");
    step(0, 0, 0, 5, "R3");
    step(1, 5, 1, 5, "R3");
    step(0, 0, 0, 5, "R3");
    step(1, 5, 0, 5, "R7");
    step(0, 0, 0, 5, "R7");
    step(1, 5, 3, 5, "R4");
    step(0, 0, 0, 5, "R4");
    step(1, 5, 0, 5, "R4");
    step(0, 0, 0, 5, "R4");
    step(1, 7, 0, 7, "R6");
    step(0, 0, 0, 7, "R6");
    sweep("R8");
    sweep("R5");
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, SETS - 1),
           $urandom_range(0, WAYS - 1), $urandom_range(0, SETS - 1), "R2_R3_R4");
    sweep("R4");
    @(negedge clk) rst_n = 0;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mdl[s][w] = 1;
    @(negedge clk) rst_n = 1;
    sweep("R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule